// File: doc/BRIEF.md
# Compressed-Sensing Readout Sequencer

This controller generates the digital control pattern for block-based compressed-sensing readout of a square pixel array. The array is tiled into square pixel blocks. Each block row is read one group of blocks at a time. Each group is read twice: first for pixel reset levels, then for signal levels. Within each pass the pixel rows of the block are visited in turn, and every row is read in a fixed number of select slots.

On each cycle of a frame the block drives four outputs. The global row select says which pixel row is read. A mask says which blocks belong to the current group. Each column selector gets a one-hot code, rotated by a different amount. A vector of include bits, taken from a pseudo-random generator, decides whether each selected pixel reaches its converter input or is replaced by a reference level.

Three compression ratios share one measurement pattern across all blocks. The ratio sets how many blocks are read at once and how many slots make up a row. A bypass mode reads every column of every row directly. A single `start` pulse runs a full frame. A one-cycle pulse marks its end.

Top module: `cs_readout_seq`

## Requirements
- R1: After reset, `busy` and `frame_done` are 0, and `blk_en`, `col_sel` and `incl` are all zero. These three outputs are also all zero whenever `busy` is 0.
- R2: A `start` seen while idle sets `busy` on the next clock edge. The frame then spends one cycle per step. The counters run from fastest to slowest in this order: `slot`, then `pix_row`, then `phase`, then `grp`, then `blk_row`. All counters start at 0.
- R3: `mode_i` is captured when the frame starts, with this encoding: 0 = ratio 1/4, 1 = ratio 1/8, 2 = ratio 1/16, 3 = bypass. The number of groups per block row is NBLK/4, NBLK/8, 1 and 1 for these modes. A row takes BLK/2 slots in the three compressed modes and BLK slots in bypass.
- R4: Block n is set in `blk_en` exactly when n mod G equals `grp`, where G is the number of groups.
- R5: In the compressed modes, selector j occupies bits [j*BLK +: BLK] of `col_sel`. Its single set bit is at position (2*slot + j + pix_row) mod BLK. In bypass, every selector has only bit `slot` set.
- R6: In the compressed modes, `incl` shows a 16-bit LFSR state. The state is reloaded with SEED on the first step of every phase and advances once per step. Each advance shifts left and feeds in bit15^bit13^bit12^bit10. In bypass, `incl` is all ones.
- R7: `phase` is 0 for the reset pass and 1 for the signal pass. Both passes of a group produce the same sequence of `col_sel` and `incl`.
- R8: `row_sel` equals `blk_row`*BLK + `pix_row`.
- R9: After the last step of the last block row, `busy` falls. In the same cycle `frame_done` is high, and it stays high for exactly one cycle.
- R10: While `busy` is 1, the block ignores `start` and any change on `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame when idle |
| mode_i | input | 2 | Ratio/bypass select, captured at start |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| phase | output | 1 | 0 reset pass, 1 signal pass |
| blk_row | output | BW | Current block row |
| grp | output | BW | Current block group |
| pix_row | output | CW | Pixel row inside the block |
| slot | output | CW | Select slot inside the row |
| row_sel | output | BW+CW | Global pixel row select |
| blk_en | output | NBLK | Blocks in the current group |
| col_sel | output | NSEL*BLK | One-hot code per column selector |
| incl | output | 16 | Include/exclude bit per converter input |

## Verification
Two situations are hard to reach from the ports: a second `start` or a new mode arriving in the middle of a frame, and the seed reload at a phase boundary deep inside a long frame. The stimulus drives random `start` and `mode_i` values on every cycle of a frame and expects them to have no effect. It compares every step of whole frames, in all four modes, against a nested-loop model. That model reloads its own LFSR at each phase. A missed reload or a restart therefore shows up as a mismatch.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        MODE_R4  = 2'd0,
        MODE_R8  = 2'd1,
        MODE_R16 = 2'd2,
        MODE_BYP = 2'd3
    } cs_mode_e;

    // one Fibonacci step, polynomial x^16+x^14+x^13+x^11+1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/cs_col_code.sv
module cs_col_code #(
    parameter int BLK  = 16,
    parameter int NSEL = 4,
    localparam int CW  = $clog2(BLK)
) (
    input  logic                  bypass,
    input  logic [CW-1:0]         slot,
    input  logic [CW-1:0]         pix_row,
    output logic [NSEL*BLK-1:0]   code
);
    for (genvar j = 0; j < NSEL; j++) begin : g_sel
        logic [CW-1:0] pos;
        always_comb begin
            if (bypass) pos = slot;
            else        pos = {slot[CW-2:0], 1'b0} + CW'(j) + pix_row;
        end
        for (genvar c = 0; c < BLK; c++) begin : g_bit
            assign code[j*BLK + c] = (pos == CW'(c));
        end
    end
endmodule

// File: rtl/cs_blk_mask.sv
module cs_blk_mask #(
    parameter int NBLK = 16,
    localparam int BW  = $clog2(NBLK)
) (
    input  logic            active,
    input  logic [BW-1:0]   gmask,
    input  logic [BW-1:0]   grp,
    output logic [NBLK-1:0] en
);
    for (genvar n = 0; n < NBLK; n++) begin : g_blk
        assign en[n] = active && ((BW'(n) & gmask) == grp);
    end
endmodule

// File: rtl/cs_readout_seq.sv
module cs_readout_seq
    import cs_seq_pkg::*;
#(
    parameter int BLK  = 16,
    parameter int NBLK = 16,
    parameter int NSEL = 4,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int CW  = $clog2(BLK),
    localparam int BW  = $clog2(NBLK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode_i,
    output logic                busy,
    output logic                frame_done,
    output logic                phase,
    output logic [BW-1:0]       blk_row,
    output logic [BW-1:0]       grp,
    output logic [CW-1:0]       pix_row,
    output logic [CW-1:0]       slot,
    output logic [BW+CW-1:0]    row_sel,
    output logic [NBLK-1:0]     blk_en,
    output logic [NSEL*BLK-1:0] col_sel,
    output logic [LFSR_W-1:0]   incl
);
    localparam logic [CW-1:0] SLOT_CS  = CW'(BLK/2 - 1);
    localparam logic [CW-1:0] SLOT_BYP = CW'(BLK - 1);
    localparam logic [CW-1:0] ROW_LAST = CW'(BLK - 1);
    localparam logic [BW-1:0] BR_LAST  = BW'(NBLK - 1);
    localparam logic [BW-1:0] GM_R4    = BW'(NBLK/4 - 1);
    localparam logic [BW-1:0] GM_R8    = BW'(NBLK/8 - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        cs_mode_e          mode;
        logic              phase;
        logic [BW-1:0]     blk_row;
        logic [BW-1:0]     grp;
        logic [CW-1:0]     pix_row;
        logic [CW-1:0]     slot;
        logic [LFSR_W-1:0] lfsr;
    } seq_t;

    seq_t st_q, st_d;
    logic          byp;
    logic [CW-1:0] slot_last;
    logic [BW-1:0] gmask;
    logic [NSEL*BLK-1:0] code;
    logic [NBLK-1:0]     mask;

    always_comb begin
        byp       = (st_q.mode == MODE_BYP);
        slot_last = byp ? SLOT_BYP : SLOT_CS;
        case (st_q.mode)
            MODE_R4: gmask = GM_R4;
            MODE_R8: gmask = GM_R8;
            default: gmask = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.mode    = cs_mode_e'(mode_i);
                st_d.phase   = 1'b0;
                st_d.blk_row = '0;
                st_d.grp     = '0;
                st_d.pix_row = '0;
                st_d.slot    = '0;
                st_d.lfsr    = SEED;
            end
        end else begin
            st_d.lfsr = lfsr_next(st_q.lfsr);
            st_d.slot = st_q.slot + 1'b1;
            if (st_q.slot == slot_last) begin
                st_d.slot    = '0;
                st_d.pix_row = st_q.pix_row + 1'b1;
                if (st_q.pix_row == ROW_LAST) begin
                    st_d.pix_row = '0;
                    st_d.lfsr    = SEED;
                    st_d.phase   = ~st_q.phase;
                    if (st_q.phase) begin
                        st_d.grp = st_q.grp + 1'b1;
                        if (st_q.grp == gmask) begin
                            st_d.grp     = '0;
                            st_d.blk_row = st_q.blk_row + 1'b1;
                            if (st_q.blk_row == BR_LAST) begin
                                st_d.blk_row = '0;
                                st_d.busy    = 1'b0;
                                st_d.done    = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    cs_col_code #(.BLK(BLK), .NSEL(NSEL)) col_i (
        .bypass (byp),
        .slot   (st_q.slot),
        .pix_row(st_q.pix_row),
        .code   (code)
    );

    cs_blk_mask #(.NBLK(NBLK)) msk_i (
        .active(st_q.busy),
        .gmask (gmask),
        .grp   (st_q.grp),
        .en    (mask)
    );

    assign busy       = st_q.busy;
    assign frame_done = st_q.done;
    assign phase      = st_q.phase;
    assign blk_row    = st_q.blk_row;
    assign grp        = st_q.grp;
    assign pix_row    = st_q.pix_row;
    assign slot       = st_q.slot;
    assign row_sel    = {st_q.blk_row, st_q.pix_row};
    assign blk_en     = mask;
    assign col_sel    = st_q.busy ? code : '0;
    assign incl       = !st_q.busy ? '0 : (byp ? '1 : st_q.lfsr);
endmodule

// File: rtl/cs_readout_seq_chk.sv
module cs_readout_seq_chk #(
    parameter int BLK  = 16,
    parameter int NBLK = 16,
    parameter int NSEL = 4,
    localparam int CW  = $clog2(BLK),
    localparam int BW  = $clog2(NBLK)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                frame_done,
    input logic [BW-1:0]       grp,
    input logic [CW-1:0]       slot,
    input logic [NBLK-1:0]     blk_en,
    input logic [NSEL*BLK-1:0] col_sel,
    input logic [15:0]         incl
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (blk_en == '0 && col_sel == '0 && incl == '0));

    p_slot_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (slot != $past(slot)));

    p_grp_member_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> blk_en[grp]);

    p_one_per_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(col_sel) == NSEL));

    p_incl_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (incl != '0));

    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(busy) && !busy));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind cs_readout_seq cs_readout_seq_chk #(.BLK(BLK), .NBLK(NBLK), .NSEL(NSEL)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
    .grp(grp), .slot(slot), .blk_en(blk_en), .col_sel(col_sel), .incl(incl)
);

// File: tb/cs_readout_seq_tb.sv
module cs_readout_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLK  = 16;
    localparam int NBLK = 16;
    localparam int NSEL = 4;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int CW = $clog2(BLK);
    localparam int BW = $clog2(NBLK);
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic busy, frame_done, phase;
    logic [BW-1:0] blk_row, grp;
    logic [CW-1:0] pix_row, slot;
    logic [BW+CW-1:0] row_sel;
    logic [NBLK-1:0] blk_en;
    logic [NSEL*BLK-1:0] col_sel;
    logic [15:0] incl;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_readout_seq #(.BLK(BLK), .NBLK(NBLK), .NSEL(NSEL), .SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i),
        .busy(busy), .frame_done(frame_done), .phase(phase),
        .blk_row(blk_row), .grp(grp), .pix_row(pix_row), .slot(slot),
        .row_sel(row_sel), .blk_en(blk_en), .col_sel(col_sel), .incl(incl)
    );

    function automatic logic [15:0] m_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int m_groups(input int m);
        if (m == 0) return NBLK/4;
        if (m == 1) return NBLK/8;
        return 1;
    endfunction

    function automatic logic [NBLK-1:0] m_blk_en(input int m, input int g);
        logic [NBLK-1:0] v = '0;
        for (int n = 0; n < NBLK; n++) v[n] = ((n % m_groups(m)) == g);
        return v;
    endfunction

    function automatic logic [NSEL*BLK-1:0] m_col(input int m, input int s, input int r);
        logic [NSEL*BLK-1:0] v = '0;
        for (int j = 0; j < NSEL; j++) begin
            if (m == 3) v[j*BLK + s] = 1'b1;
            else        v[j*BLK + ((2*s + j + r) % BLK)] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {62'd0, busy, frame_done}, 64'd0);
        check(req, {blk_en, incl}, 64'd0);
        check(req, col_sel, 64'd0);
    endtask

    task automatic run_frame(input int m, input bit noisy);
        logic [15:0] lf;
        int nslot;
        nslot = (m == 3) ? BLK : BLK/2;
        @(negedge clk);
        start  = 1'b1;
        mode_i = 2'(m);
        @(negedge clk);
        start = 1'b0;
        for (int br = 0; br < NBLK; br++)
            for (int g = 0; g < m_groups(m); g++)
                for (int ph = 0; ph < 2; ph++) begin
                    lf = SEED;
                    for (int r = 0; r < BLK; r++)
                        for (int s = 0; s < nslot; s++) begin
                            check("R2 counters", {busy, phase, 10'(blk_row), 10'(grp), 10'(pix_row), 10'(slot)},
                                  {1'b1, 1'(ph), 10'(br), 10'(g), 10'(r), 10'(s)});
                            check("R8 row_sel", 64'(row_sel), 64'(br*BLK + r));
                            check("R4 blk_en", 64'(blk_en), 64'(m_blk_en(m, g)));
                            check("R5 col_sel", col_sel, m_col(m, s, r));
                            check("R6 R7 incl", 64'(incl), (m == 3) ? 64'hFFFF : 64'(lf));
                            check("R9 no early done", 64'(frame_done), 64'd0);
                            lf = m_lfsr(lf);
                            if (noisy) begin // R10: disturbances while busy
                                start  = 1'($urandom % 2);
                                mode_i = 2'($urandom % 4);
                            end
                            @(negedge clk);
                        end
                end
        start = 1'b0;
        check("R9 done pulse", {62'd0, busy, frame_done}, 64'b01);
        @(negedge clk);
        check("R9 done single", 64'(frame_done), 64'd0);
        check_idle("R1 idle after frame");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected frame end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        // R3 each mode directed, quiet inputs
        run_frame(0, 1'b0);
        run_frame(1, 1'b0);
        run_frame(2, 1'b0);
        run_frame(3, 1'b0);
        // R10 random modes with random start/mode noise mid-frame
        for (int k = 0; k < 3; k++) begin
            int m;
            int gap;
            m = int'($urandom % 4);
            if (m == 0) m = 2;
            gap = int'($urandom % 5);
            repeat (gap) begin
                @(negedge clk);
                check_idle("R1 idle gap");
            end
            run_frame(m, 1'b1);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule